// File: doc/BRIEF.md
# Platform Interrupt Router with Claim and Completion

This block gathers level-sensitive interrupt requests from a fixed number of device sources and distributes them to a set of targets. Each target stands for one privilege mode on one hardware thread, for example the machine-mode and supervisor-mode contexts of a thread. Per-source priorities, per-target enable masks and per-target priority thresholds are written through simple write ports. Each target gets one interrupt line.

Software running in a target claims an interrupt by pulsing a claim strobe with its target number. In the same cycle the block returns the ID of the best pending source enabled for that target. Taking that ID removes the source from contention for every target. The source stays out of contention until software writes the same ID back as a completion. Source ID 0 is reserved and means "nothing to service".

Top module: `irq_router`

## Requirements
- R1: After reset every priority, enable, threshold, pending and in-service bit is zero, all `irq_o` bits are low and `claim_id_o` reads 0.
- R2: Input bit `src_i[s-1]` drives source ID s. A high input sets the source's pending bit at the next edge, unless the source is in service. Once set, the pending bit stays set until the source is claimed, even if the input drops. A source whose priority is 0 is never offered to any target.
- R3: Each target has its own enable bit for each source. A source is offered to a target only if that target's bit is set. Writes to source ID 0, to IDs above the source count, or to target numbers at or above the target count change nothing.
- R4: While `claim_i` is high, `claim_id_o` shows the pending, enabled, nonzero-priority source with the highest priority for `claim_tgt_i`. On equal priority the lower ID wins. It shows 0 when no source qualifies, when the target number is out of range, or when `claim_i` is low.
- R5: Bit t of `irq_o` is high exactly when target t has a qualifying source whose priority is at least that target's threshold. The threshold does not change what a claim returns.
- R6: At the edge that ends a claim cycle with a nonzero ID, the source's pending bit clears and the source enters service. While in service it never becomes pending and no target can claim it, even if its input stays high.
- R7: A completion releases a source only if the source is in service and enabled in the completing target. Any other completion, including one with an out-of-range target, is ignored.
- R8: `irq_o` is registered. It reflects the pending, enable, priority and threshold state of the previous cycle, so a change appears one edge after the state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level requests; bit s-1 is source ID s |
| prio_we_i | input | 1 | Priority write strobe |
| prio_id_i | input | ID_W | Source ID for the priority write |
| prio_val_i | input | PRIO_W | Priority value |
| en_we_i | input | 1 | Enable write strobe |
| en_tgt_i | input | TGT_W | Target for the enable write |
| en_id_i | input | ID_W | Source ID for the enable write |
| en_val_i | input | 1 | Enable bit value |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_tgt_i | input | TGT_W | Target for the threshold write |
| thr_val_i | input | PRIO_W | Threshold value |
| claim_i | input | 1 | Claim strobe |
| claim_tgt_i | input | TGT_W | Claiming target |
| claim_id_o | output | ID_W | Claimed source ID, 0 for none |
| cmpl_i | input | 1 | Completion strobe |
| cmpl_tgt_i | input | TGT_W | Completing target |
| cmpl_id_i | input | ID_W | Source ID being completed |
| irq_o | output | NUM_TGT | Interrupt line per target |

## Verification
The assertions run on every cycle for every source. They check that a claimed ID was pending at the moment of the claim, and that it lands in service with its pending bit cleared. They also check that a source in service never shows as pending, that it stays in service until a completion names it, and that the claim output is zero when no claim is active. Some behaviours depend on the whole configuration and can only be shown by the bench scenarios run against its reference model: priority ordering with the low-ID tie break, per-target enable isolation, threshold masking of the line but not of the claim, refusal of completions from targets without the enable, and the one-edge lag of `irq_o`.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned DefNumSrc = 10;
  localparam int unsigned DefNumTgt = 9;
  localparam int unsigned DefPrioW  = 3;

  function automatic int unsigned idw(int unsigned n);
    return $clog2(n + 1);
  endfunction

  function automatic int unsigned tgtw(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic claim_i,
  input  logic cmpl_i,
  output logic pend_o,
  output logic busy_o
);
  logic pend_q, busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (claim_i) begin
      pend_q <= 1'b0;
      busy_q <= 1'b1;
    end else if (cmpl_i && busy_q) begin
      busy_q <= 1'b0;
    end else if (req_i && !busy_q) begin
      pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/irq_tgt_arb.sv
module irq_tgt_arb #(
  parameter int unsigned NUM_SRC = 10,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ID_W    = 4
) (
  input  logic [NUM_SRC:1]             pend_i,
  input  logic [NUM_SRC:1]             en_i,
  input  logic [NUM_SRC:1][PRIO_W-1:0] prio_i,
  output logic [ID_W-1:0]              id_o,
  output logic [PRIO_W-1:0]            prio_o
);
  // ascending scan, strict compare: lower ID keeps ties
  always_comb begin
    id_o   = '0;
    prio_o = '0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      if (pend_i[s] && en_i[s] && (prio_i[s] > prio_o)) begin
        prio_o = prio_i[s];
        id_o   = ID_W'(s);
      end
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = DefNumSrc,
  parameter int unsigned NUM_TGT = DefNumTgt,
  parameter int unsigned PRIO_W  = DefPrioW,
  parameter int unsigned ID_W    = idw(NUM_SRC),
  parameter int unsigned TGT_W   = tgtw(NUM_TGT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               prio_we_i,
  input  logic [ID_W-1:0]    prio_id_i,
  input  logic [PRIO_W-1:0]  prio_val_i,
  input  logic               en_we_i,
  input  logic [TGT_W-1:0]   en_tgt_i,
  input  logic [ID_W-1:0]    en_id_i,
  input  logic               en_val_i,
  input  logic               thr_we_i,
  input  logic [TGT_W-1:0]   thr_tgt_i,
  input  logic [PRIO_W-1:0]  thr_val_i,
  input  logic               claim_i,
  input  logic [TGT_W-1:0]   claim_tgt_i,
  output logic [ID_W-1:0]    claim_id_o,
  input  logic               cmpl_i,
  input  logic [TGT_W-1:0]   cmpl_tgt_i,
  input  logic [ID_W-1:0]    cmpl_id_i,
  output logic [NUM_TGT-1:0] irq_o
);
  logic [NUM_SRC:1][PRIO_W-1:0]  prio_q;
  logic [NUM_TGT-1:0][NUM_SRC:1] en_q;
  logic [NUM_TGT-1:0][PRIO_W-1:0] thr_q;
  logic [NUM_TGT-1:0][ID_W-1:0]   best_id;
  logic [NUM_TGT-1:0][PRIO_W-1:0] best_prio;
  logic [NUM_SRC:1] pend, busy, claim_hit, cmpl_hit;
  logic [NUM_SRC:1] cmpl_row;
  logic [NUM_TGT-1:0] irq_q;

  // priority registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prio_q <= '0;
    else if (prio_we_i) begin
      for (int s = 1; s <= NUM_SRC; s++)
        if (prio_id_i == ID_W'(s)) prio_q[s] <= prio_val_i;
    end
  end

  // enable and threshold registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      thr_q <= '0;
    end else begin
      for (int t = 0; t < NUM_TGT; t++) begin
        if (en_we_i && (en_tgt_i == TGT_W'(t))) begin
          for (int s = 1; s <= NUM_SRC; s++)
            if (en_id_i == ID_W'(s)) en_q[t][s] <= en_val_i;
        end
        if (thr_we_i && (thr_tgt_i == TGT_W'(t))) thr_q[t] <= thr_val_i;
      end
    end
  end

  // claim and completion target muxes
  always_comb begin
    claim_id_o = '0;
    cmpl_row   = '0;
    for (int t = 0; t < NUM_TGT; t++) begin
      if (claim_i && (claim_tgt_i == TGT_W'(t))) claim_id_o = best_id[t];
      if (cmpl_i && (cmpl_tgt_i == TGT_W'(t)))   cmpl_row   = en_q[t];
    end
  end

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    assign claim_hit[s] = (claim_id_o == ID_W'(s));
    assign cmpl_hit[s]  = cmpl_i && (cmpl_id_i == ID_W'(s)) && cmpl_row[s];

    irq_gateway i_gw (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (src_i[s-1]),
      .claim_i (claim_hit[s]),
      .cmpl_i  (cmpl_hit[s]),
      .pend_o  (pend[s]),
      .busy_o  (busy[s])
    );
  end

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    irq_tgt_arb #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .ID_W    (ID_W)
    ) i_arb (
      .pend_i (pend),
      .en_i   (en_q[t]),
      .prio_i (prio_q),
      .id_o   (best_id[t]),
      .prio_o (best_prio[t])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q[t] <= 1'b0;
      else         irq_q[t] <= (best_id[t] != '0) && (best_prio[t] >= thr_q[t]);
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int unsigned NUM_SRC = 10,
  parameter int unsigned ID_W    = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            claim_i,
  input logic [ID_W-1:0] claim_id_o,
  input logic            cmpl_i,
  input logic [ID_W-1:0] cmpl_id_i,
  input logic [NUM_SRC:1] pend,
  input logic [NUM_SRC:1] busy
);
  a_r4_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !claim_i |-> (claim_id_o == '0));

  a_r4_id_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_id_o <= ID_W'(NUM_SRC));

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_s
    a_r6_claimed_was_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (claim_i && claim_id_o == ID_W'(s)) |-> pend[s]);

    a_r6_claim_enters_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (claim_i && claim_id_o == ID_W'(s)) |=> (busy[s] && !pend[s]));

    a_r6_no_pend_in_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy[s] |-> !pend[s]);

    a_r7_service_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy[s] && !(cmpl_i && cmpl_id_i == ID_W'(s))) |=> busy[s]);
  end
endmodule

bind irq_router irq_router_chk #(
  .NUM_SRC (NUM_SRC),
  .ID_W    (ID_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .claim_i    (claim_i),
  .claim_id_o (claim_id_o),
  .cmpl_i     (cmpl_i),
  .cmpl_id_i  (cmpl_id_i),
  .pend       (pend),
  .busy       (busy)
);

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;
  localparam int N  = 10;
  localparam int NT = 9;
  localparam int PW = 3;
  localparam int IW = 4;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_i = '0;
  logic prio_we = 0, en_we = 0, thr_we = 0, claim = 0, cmpl = 0, en_val = 0;
  logic [IW-1:0] prio_id = '0, en_id = '0, cmpl_id = '0;
  logic [PW-1:0] prio_val = '0, thr_val = '0;
  logic [TW-1:0] en_tgt = '0, thr_tgt = '0, claim_tgt = '0, cmpl_tgt = '0;
  logic [IW-1:0] claim_id;
  logic [NT-1:0] irq;

  int errors = 0, checks = 0;
  bit done = 0;

  int prio_m[1:N];
  bit en_m[NT][1:N];
  int thr_m[NT];
  bit pend_m[1:N], busy_m[1:N];
  bit [NT-1:0] exp_irq;

  always #2.5 clk = ~clk;

  irq_router i_irq_router (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src_i),
    .prio_we_i(prio_we), .prio_id_i(prio_id), .prio_val_i(prio_val),
    .en_we_i(en_we), .en_tgt_i(en_tgt), .en_id_i(en_id), .en_val_i(en_val),
    .thr_we_i(thr_we), .thr_tgt_i(thr_tgt), .thr_val_i(thr_val),
    .claim_i(claim), .claim_tgt_i(claim_tgt), .claim_id_o(claim_id),
    .cmpl_i(cmpl), .cmpl_tgt_i(cmpl_tgt), .cmpl_id_i(cmpl_id),
    .irq_o(irq)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int best(int t);
    int b = 0, bp = 0;
    for (int s = 1; s <= N; s++)
      if (pend_m[s] && en_m[t][s] && prio_m[s] > bp) begin bp = prio_m[s]; b = s; end
    return b;
  endfunction

  function automatic bit line(int t);
    int b = best(t);
    return (b != 0) && (prio_m[b] >= thr_m[t]);
  endfunction

  task automatic set_src(int s, bit v);
    src_i[s-1] = v;
  endtask

  // op: 0 idle, 1 prio(a=id,b=val), 2 enable(a=tgt,b=id,c=val),
  // 3 threshold(a=tgt,b=val), 4 claim(a=tgt), 5 complete(a=tgt,b=id)
  task automatic cycle(int op, int a, int b, int c, string tag);
    bit [NT-1:0] nxt;
    int exp_id = 0;
    @(negedge clk);
    prio_we = 0; en_we = 0; thr_we = 0; claim = 0; cmpl = 0;
    case (op)
      1: begin prio_we = 1; prio_id = IW'(a); prio_val = PW'(b); end
      2: begin en_we = 1; en_tgt = TW'(a); en_id = IW'(b); en_val = c[0]; end
      3: begin thr_we = 1; thr_tgt = TW'(a); thr_val = PW'(b); end
      4: begin claim = 1; claim_tgt = TW'(a); end
      5: begin cmpl = 1; cmpl_tgt = TW'(a); cmpl_id = IW'(b); end
      default: ;
    endcase
    #1;
    if (op == 4) begin
      exp_id = (a < NT) ? best(a) : 0;
      chk(claim_id == IW'(exp_id), tag, int'(claim_id), exp_id);
    end
    for (int t = 0; t < NT; t++) nxt[t] = line(t);
    @(posedge clk);
    for (int s = 1; s <= N; s++) begin
      bit ch = (op == 4) && (exp_id == s);
      bit dh = (op == 5) && (b == s) && (a < NT) && en_m[a < NT ? a : 0][s] && busy_m[s];
      if (ch) begin pend_m[s] = 0; busy_m[s] = 1; end
      else if (dh) busy_m[s] = 0;
      else if (src_i[s-1] && !busy_m[s]) pend_m[s] = 1;
    end
    if (op == 1 && a >= 1 && a <= N) prio_m[a] = b;
    if (op == 2 && a < NT && b >= 1 && b <= N) en_m[a][b] = c[0];
    if (op == 3 && a < NT) thr_m[a] = b;
    exp_irq = nxt;
    #1;
    chk(irq == exp_irq, "R5/R8 irq_o", int'(irq), int'(exp_irq));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 1; s <= N; s++) begin prio_m[s] = 0; pend_m[s] = 0; busy_m[s] = 0; end
    for (int t = 0; t < NT; t++) begin
      thr_m[t] = 0;
      for (int s = 1; s <= N; s++) en_m[t][s] = 0;
    end
    exp_irq = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(irq == '0, "R1 irq_o in reset", int'(irq), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(irq == '0 && claim_id == '0, "R1 after reset", int'(irq), 0);

    // R4 nothing pending: claim returns 0
    cycle(4, 0, 0, 0, "R4 empty claim");
    // R4 tie and ordering
    cycle(1, 3, 2, 0, "");  cycle(1, 5, 2, 0, ""); cycle(1, 7, 5, 0, "");
    cycle(2, 0, 3, 1, ""); cycle(2, 0, 5, 1, "");
    cycle(2, 1, 7, 1, ""); cycle(2, 1, 3, 1, "");
    set_src(3, 1); set_src(5, 1); set_src(7, 1);
    cycle(0, 0, 0, 0, ""); cycle(0, 0, 0, 0, "");
    cycle(4, 0, 0, 0, "R4 tie picks lower id");
    cycle(4, 1, 0, 0, "R4 higher priority wins");
    // R6: source 3 in service, input still high, target 1 cannot take it
    cycle(0, 0, 0, 0, "");
    cycle(4, 1, 0, 0, "R6 in-service source held off");
    // R3: target 2 has no enables
    cycle(4, 2, 0, 0, "R3 unenabled target");
    cycle(2, 15, 5, 1, ""); cycle(1, 0, 7, 0, "");
    cycle(4, 2, 0, 0, "R3 out-of-range write ignored");
    // R7: completion from target without enable, and of idle source
    cycle(5, 2, 7, 0, ""); cycle(5, 0, 9, 0, ""); cycle(5, 12, 3, 0, "");
    cycle(0, 0, 0, 0, "");
    cycle(4, 1, 0, 0, "R7 bogus completion ignored");
    cycle(5, 1, 7, 0, ""); cycle(0, 0, 0, 0, "");
    cycle(4, 1, 0, 0, "R7 valid completion releases");
    // R5 threshold masks line, not claim
    cycle(3, 0, 7, 0, ""); cycle(0, 0, 0, 0, "");
    chk(irq[0] == 1'b0, "R5 threshold masks line", int'(irq[0]), 0);
    cycle(4, 0, 0, 0, "R5 claim ignores threshold");
    // R2 priority 0 never taken; pending held after input drop
    cycle(2, 3, 9, 1, ""); set_src(9, 1); cycle(0, 0, 0, 0, "");
    cycle(4, 3, 0, 0, "R2 priority zero not offered");
    set_src(9, 0); cycle(1, 9, 4, 0, ""); cycle(0, 0, 0, 0, "");
    cycle(4, 3, 0, 0, "R2 pending kept after input drop");
    cycle(4, 11, 0, 0, "R4 out-of-range target");

    for (int i = 0; i < 1500; i++) begin
      int op = $urandom_range(0, 6);
      int t = $urandom_range(0, NT);
      int s = $urandom_range(0, N);
      if (op == 6) begin
        set_src($urandom_range(1, N), 1'($urandom_range(0, 1)));
        cycle(0, 0, 0, 0, "");
      end else if (op == 5 && $urandom_range(0, 1) == 1) begin
        int pick = 0;
        for (int k = 1; k <= N; k++) if (busy_m[k]) pick = k;
        cycle(5, t, pick, 0, "");
      end else begin
        cycle(op, (op == 1) ? s : t, (op == 1 || op == 3) ? $urandom_range(0, 7) : s,
              $urandom_range(0, 1), "R4/R6 random claim");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule